// File: doc/BRIEF.md
# Framed Serial Configuration Word Loader

This block takes configuration words from a write-only three-wire serial link (a serial clock, a serial data line and an active-low frame strobe that also acts as chip enable) and delivers them as parallel 16-bit register writes in the system clock domain. Bits are shifted in on falling edges of the serial clock while the frame strobe is low. The first bit is the word's most significant bit. Every sixteenth falling edge completes a word.

A completed word is held in the serial domain and handed to the system domain through a toggle handshake. There it shows up as a one-cycle valid pulse together with the word and a two-bit destination code taken from the word's top two bits. Code 00 addresses the control register and raises a separate control-write strobe. The other three codes pass through with the word for other register classes to pick up.

A single frame may carry any whole number of words back to back. A frame that ends part-way through a word drops the incomplete bits. The serial clock may idle high, idle low or run freely between frames.

Top module: `frame_word_loader`

## Requirements
- R1: While `rst_i` is high and in the first cycle after it falls, `word_vld_o` and `ctrl_wr_o` are 0 and `word_o` and `dest_o` are 0.
- R2: Bits are taken from `ser_dat_i` only on falling edges of `ser_clk_i` while `ser_frame_n_i` is low. The first bit of a word lands in `word_o[15]` and the sixteenth in `word_o[0]`.
- R3: Each completed word produces exactly one `word_vld_o` pulse one system cycle wide. `word_o` keeps its value until the next pulse.
- R4: With `ser_frame_n_i` held low for k×16 falling edges, k words are delivered in the order they were sent.
- R5: If `ser_frame_n_i` rises before the sixteenth falling edge of a word, no pulse is produced for that word and the bit position returns to the start. The next frame's first bit lands in `word_o[15]`.
- R6: Delivery is the same when the serial clock idles high, idles low or runs continuously. Serial clock edges while `ser_frame_n_i` is high change nothing at the outputs.
- R7: `dest_o` equals bits 15:14 of the delivered word. `ctrl_wr_o` pulses together with `word_vld_o` exactly when those bits are 00, and stays low for codes 01, 10 and 11.
- R8: With the default two synchroniser stages, `word_vld_o` is high in the window after the third rising edge of `clk_i` that follows the completing serial falling edge. In general this is SYNC_STAGES+1 rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset (also clears the serial-domain handshake flag) |
| ser_clk_i | input | 1 | Serial clock; data sampled on its falling edge |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_frame_n_i | input | 1 | Active-low frame strobe and chip enable |
| word_vld_o | output | 1 | One-cycle pulse per delivered word |
| word_o | output | 16 | Last delivered word |
| dest_o | output | 2 | Destination code, bits 15:14 of the word |
| ctrl_wr_o | output | 1 | Control-register write strobe (destination 00) |

## Verification
The assertions assume that consecutive word completions are separated by many more system cycles than the synchroniser depth. This keeps the handed-over word stable while the system domain samples it. The stimulus runs the serial clock at one quarter of the system rate, so there are always 64 system cycles between completions. The assertions also assume that serial clock edges never coincide with rising edges of `clk_i`. The bench moves every serial and frame line only on falling edges of the system clock, so no edge ever meets a rising edge and the latency of R8 comes out as an exact count.

// File: rtl/fwl_pkg.sv
package fwl_pkg;

    localparam int WORD_W = 16;
    localparam int DEST_W = 2;
    localparam int BODY_W = WORD_W - DEST_W;
    localparam int CNT_W  = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [DEST_W-1:0] {
        DST_CTRL  = 2'b00,
        DST_CLS_A = 2'b01,
        DST_CLS_B = 2'b10,
        DST_CLS_C = 2'b11
    } dest_e;

    typedef struct packed {
        dest_e              dest;
        logic [BODY_W-1:0]  body;
    } word_s;

    function automatic dest_e dest_of(word_t w);
        word_s s;
        s = word_s'(w);
        return s.dest;
    endfunction

    function automatic logic is_last_bit(logic [CNT_W-1:0] cnt);
        return cnt == CNT_W'(WORD_W - 1);
    endfunction

endpackage

// File: rtl/fwl_ser_capture.sv
// Serial-domain capture: shift register and bit counter are cleared
// asynchronously while the frame strobe is high; a completed word is
// copied into a hold register and announced by flipping a toggle flag.
module fwl_ser_capture
    import fwl_pkg::*;
(
    input  logic  rst_i,
    input  logic  ser_clk_i,
    input  logic  ser_dat_i,
    input  logic  ser_frame_n_i,
    output word_t hold_o,
    output logic  tog_o
);

    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-2:0] shift_q;
    word_t             next_word;
    logic              word_done;

    assign next_word = {shift_q, ser_dat_i};
    assign word_done = is_last_bit(bit_cnt);

    always_ff @(negedge ser_clk_i or posedge ser_frame_n_i) begin
        if (ser_frame_n_i) begin
            bit_cnt <= '0;
            shift_q <= '0;
        end else begin
            shift_q <= next_word[WORD_W-2:0];
            if (word_done) begin
                bit_cnt <= '0;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    always_ff @(negedge ser_clk_i or posedge rst_i) begin
        if (rst_i) begin
            hold_o <= '0;
            tog_o  <= 1'b0;
        end else if (!ser_frame_n_i && word_done) begin
            hold_o <= next_word;
            tog_o  <= ~tog_o;
        end
    end

endmodule

// File: rtl/fwl_tog_sync.sv
// Multi-stage synchroniser of a toggle flag with change detection.
module fwl_tog_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tog_i,
    output logic pulse_o
);

    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("fwl_tog_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], tog_i};
        end
    end

    assign pulse_o = chain_q[CHAIN_W-1] ^ chain_q[CHAIN_W-2];

endmodule

// File: rtl/fwl_route.sv
// System-domain output stage: registers the word and decodes its destination.
module fwl_route
    import fwl_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  take_i,
    input  word_t hold_i,
    output logic  vld_o,
    output word_t word_o,
    output dest_e dest_o,
    output logic  ctrl_wr_o
);

    dest_e hold_dest;

    assign hold_dest = dest_of(hold_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            vld_o     <= 1'b0;
            ctrl_wr_o <= 1'b0;
            word_o    <= '0;
            dest_o    <= DST_CTRL;
        end else begin
            vld_o     <= take_i;
            ctrl_wr_o <= take_i && (hold_dest == DST_CTRL);
            if (take_i) begin
                word_o <= hold_i;
                dest_o <= hold_dest;
            end
        end
    end

endmodule

// File: rtl/frame_word_loader.sv
module frame_word_loader
    import fwl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_frame_n_i,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o,
    output logic [DEST_W-1:0] dest_o,
    output logic              ctrl_wr_o
);

    word_t hold_w;
    logic  tog_w;
    logic  take_w;
    dest_e dest_w;

    fwl_ser_capture cap_i (
        .rst_i         (rst_i),
        .ser_clk_i     (ser_clk_i),
        .ser_dat_i     (ser_dat_i),
        .ser_frame_n_i (ser_frame_n_i),
        .hold_o        (hold_w),
        .tog_o         (tog_w)
    );

    fwl_tog_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tog_i   (tog_w),
        .pulse_o (take_w)
    );

    fwl_route route_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .take_i    (take_w),
        .hold_i    (hold_w),
        .vld_o     (word_vld_o),
        .word_o    (word_o),
        .dest_o    (dest_w),
        .ctrl_wr_o (ctrl_wr_o)
    );

    assign dest_o = dest_w;

endmodule

// File: rtl/fwl_chk.sv
module fwl_chk
    import fwl_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              word_vld_o,
    input logic [WORD_W-1:0] word_o,
    input logic [DEST_W-1:0] dest_o,
    input logic              ctrl_wr_o
);

    // R1: the first cycle after reset is quiet
    assert_quiet_after_reset_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!word_vld_o && !ctrl_wr_o && word_o == '0 && dest_o == '0));

    // R3: valid is a single-cycle pulse
    assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        word_vld_o |=> !word_vld_o);

    // R3: the word only moves with a valid pulse
    assert_word_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !word_vld_o |-> ($stable(word_o) && $stable(dest_o)));

    // R7: control strobe only for code 00 words
    assert_ctrl_only_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl_wr_o |-> (word_vld_o && word_o[WORD_W-1 -: DEST_W] == 2'b00));

    // R7: every code 00 word raises the control strobe
    assert_ctrl_every_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (word_vld_o && word_o[WORD_W-1 -: DEST_W] == 2'b00) |-> ctrl_wr_o);

endmodule

bind frame_word_loader fwl_chk chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .word_vld_o (word_vld_o),
    .word_o     (word_o),
    .dest_o     (dest_o),
    .ctrl_wr_o  (ctrl_wr_o)
);

// File: tb/frame_word_loader_tb_top.sv
module frame_word_loader_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SER   = 2 * CLK_PERIOD;
    localparam int SYNC       = 2;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b1;
    logic        sdat = 1'b0;
    logic        sfrm_n = 1'b1;
    logic        vld;
    logic [15:0] word;
    logic [1:0]  dest;
    logic        ctrl;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];
    int          edge_q[$];
    logic [15:0] got_w[$];
    logic [1:0]  got_d[$];
    logic        got_c[$];
    int          got_t[$];
    logic [15:0] last_word = 16'h0;

    frame_word_loader #(.SYNC_STAGES(SYNC)) dut_i (
        .clk_i         (clk),
        .rst_i         (rst),
        .ser_clk_i     (sclk),
        .ser_dat_i     (sdat),
        .ser_frame_n_i (sfrm_n),
        .word_vld_o    (vld),
        .word_o        (word),
        .dest_o        (dest),
        .ctrl_wr_o     (ctrl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (vld) begin
            got_w.push_back(word);
            got_d.push_back(dest);
            got_c.push_back(ctrl);
            got_t.push_back(cyc);
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // mode: 0 idle high, 1 idle low, 2 continuous clock
    task automatic free_run(int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1; sdat = ~sdat; #HALF_SER;
            sclk = 1'b0; #HALF_SER;
        end
    endtask

    task automatic send(logic [15:0] words[], int nbits, int mode);
        int total;
        total = (nbits < 0) ? words.size() * 16 : nbits;
        if (mode == 2) free_run(3);
        sclk = (mode == 1) ? 1'b0 : 1'b1;
        #HALF_SER;
        sfrm_n = 1'b0;
        #HALF_SER;
        for (int b = 0; b < total; b++) begin
            sclk = 1'b1;
            sdat = words[b / 16][15 - (b % 16)];
            #HALF_SER;
            sclk = 1'b0;
            if (b % 16 == 15) begin
                exp_q.push_back(words[b / 16]);
                edge_q.push_back(cyc);
            end
            #HALF_SER;
        end
        sclk = (mode == 1) ? 1'b0 : 1'b1;
        #HALF_SER;
        sfrm_n = 1'b1;
        #HALF_SER;
        if (mode == 2) free_run(3);
        repeat (8) @(negedge clk);
    endtask

    task automatic compare(string req);
        check(req, "word count", got_w.size(), exp_q.size());
        while (exp_q.size() > 0 && got_w.size() > 0) begin
            logic [15:0] e;
            e = exp_q.pop_front();
            check(req, "word", got_w.pop_front(), e);
            check("R7", "dest", got_d.pop_front(), e[15:14]);
            check("R7", "ctrl strobe", got_c.pop_front(), (e[15:14] == 2'b00) ? 1 : 0);
            check("R8", "latency", got_t.pop_front() - edge_q.pop_front(), SYNC + 1);
            last_word = e;
        end
        exp_q.delete(); edge_q.delete();
        got_w.delete(); got_d.delete(); got_c.delete(); got_t.delete();
        check("R3", "word held", word, last_word);
        check("R3", "valid low between words", vld, 0);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] w1[];
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", vld, 0);
        check("R1", "word in reset", word, 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "valid after reset", vld, 0);
        check("R1", "ctrl after reset", ctrl, 0);
        check("R1", "dest after reset", dest, 0);

        // R2 R6 R7: single words, every destination, three clock modes
        w1 = new[1];
        for (int d = 0; d < 4; d++) begin
            for (int p = 0; p < 6; p++) begin
                w1[0] = 16'((d << 14) | ((p * 16'h1357 + d * 16'h0F0F + 1) & 16'h3FFF));
                send(w1, -1, p % 3);
                compare("R2");
            end
        end
        w1[0] = 16'h8000; send(w1, -1, 0); compare("R2");
        w1[0] = 16'h0001; send(w1, -1, 1); compare("R2");

        // R4: back-to-back words in one frame
        for (int n = 2; n <= 4; n++) begin
            for (int m = 0; m < 3; m++) begin
                logic [15:0] wn[];
                wn = new[n];
                for (int k = 0; k < n; k++)
                    wn[k] = 16'((k << 14) ^ (n * 16'h2345 + k * 16'h0777 + m * 16'h1111));
                send(wn, -1, m);
                compare("R4");
            end
        end

        // R5: truncated frames deliver nothing, next word aligned
        for (int k = 1; k <= 15; k++) begin
            logic [15:0] wp[];
            wp = new[1];
            wp[0] = 16'hFFFF;
            send(wp, k, k % 3);
            compare("R5");
            w1[0] = 16'((k << 10) | 16'h4005);
            send(w1, -1, (k + 1) % 3);
            compare("R5");
        end

        // R5: full word then partial word in the same frame
        begin
            logic [15:0] w2[];
            w2 = new[2];
            w2[0] = 16'hC0DE; w2[1] = 16'hFFFF;
            send(w2, 16 + 7, 2);
            compare("R5");
        end

        // R6: free-running clock with frame high leaves outputs alone
        free_run(40);
        repeat (8) @(negedge clk);
        compare("R6");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule